// File: doc/BRIEF.md
# Bit-Serial CRC-15 Engine for Destuffed Frame Streams

This block builds the 15-bit cyclic redundancy check for a serial bus frame. It works one bit at a time. It sits after the bit destuffer, so it only ever sees information bits. The covered bits start at start-of-frame and end at the last data bit. A frame with no data field ends at its last control bit. Stuff bits must never be presented to it.

The generator has degree 15: x^15+x^14+x^10+x^8+x^7+x^4+x^3+1. It is a degree-14 BCH factor multiplied by (x+1). The code length is at most 127 bits, and a frame carries at most 83 information bits. Within that length the code detects:
- every burst of 15 bits or fewer,
- every odd count of flipped bits,
- any five or fewer random flips.

The frame controller uses the block in one of two ways:
- **Sending.** The controller raises the freeze input once the data field is over. The register then stays put, and the controller shifts the value out of `crc_value` most significant bit first.
- **Receiving.** The controller keeps feeding bits through the 15 received check bits. At the check delimiter it pulses `crc_sample`. A frame received without error leaves the register at zero. A non-zero register sets `crc_error`.

Top module: `can_crc15`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) forces `crc_value` to 0 and `crc_error` to 0.
- R2: `frame_clr` high at an edge forces `crc_value` to 0 and `crc_error` to 0. This overrides `bit_valid`, `bit_in` and `crc_sample` in the same cycle.
- R3: Each bit is accepted when `bit_valid` is high, `freeze` is low and `frame_clr` is low. For each accepted bit, let f = `bit_in` XOR `crc_value[14]`. The new `crc_value` is `crc_value` shifted left by one with 0 entering bit 0, then XORed with 15'h4599 when f is 1.
- R4: While `bit_valid` is low, `crc_value` does not change, whatever `bit_in` does.
- R5: While `freeze` is high, `bit_valid` and `bit_in` are ignored and `crc_value` holds.
- R6: The remainder of a frame can be appended to that frame, most significant bit first. Feeding the whole result returns `crc_value` to 0.
- R7: `crc_sample` high at an edge (without `frame_clr`) makes `crc_error` equal, one cycle later, to whether `crc_value` was non-zero at that edge.
- R8: A valid codeword can be corrupted in three ways before it is fed in: any single bit, any two bits, or a burst of length 15 or less. A burst has both end bits flipped and any pattern between them. In every case, sampling afterwards gives `crc_error` = 1. The uncorrupted codeword gives 0.
- R9: Without `crc_sample`, `frame_clr` or reset, `crc_error` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clr | input | 1 | Start of a new frame: clears register and error flag |
| bit_valid | input | 1 | `bit_in` carries a destuffed frame bit this cycle |
| bit_in | input | 1 | Serial frame bit |
| freeze | input | 1 | Hold the register (transmit, after the data field) |
| crc_sample | input | 1 | Check strobe at the check delimiter (receive) |
| crc_value | output | 15 | Current register; the remainder once the covered bits are in |
| crc_error | output | 1 | Register was non-zero at the last check strobe |

## Verification
The hardest behaviour to reach from the ports is the guarantee of R8. No hand-picked frame exercises it. It needs a valid codeword that is then damaged in every position the guarantee covers. The bench builds the codeword from a software model of the shift rule. It then replays that codeword many times:
- with every single-bit flip,
- with every pair of flipped bits,
- with every burst start and length up to 15.

Each replay starts with a frame clear and ends with a check strobe. In every case the bench expects the error flag to rise.

// File: rtl/can_crc15_pkg.sv
// Package: shared defaults and types for the serial CRC-15 engine.
// Assumes: a degree-15 generator written without its x^15 term.
package can_crc15_pkg;
    localparam int          CRC_W_DEF = 15;
    localparam logic [14:0] POLY_DEF  = 15'h4599;

    // Register-update select for the state register
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_SHIFT = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_e;
endpackage

// File: rtl/crc15_next.sv
// Module: crc15_next
// Purpose: combinational next value of the CRC register for one input bit.
// Assumes: the register bit W-1 is the oldest term; POLY omits the top term.
module crc15_next #(
    parameter int             W    = 15,
    parameter logic [W-1:0]   POLY = 15'h4599
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;

    // Feedback term: incoming bit against the outgoing register bit
    assign fb = din ^ cur[W-1];

    // One XOR tap per register bit, present only where POLY has a one
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_tap
            if (gi == 0) begin : g_low
                if (POLY[0]) begin : g_x
                    assign nxt[0] = fb;
                end else begin : g_z
                    assign nxt[0] = 1'b0;
                end
            end else begin : g_up
                if (POLY[gi]) begin : g_x
                    assign nxt[gi] = cur[gi-1] ^ fb;
                end else begin : g_z
                    assign nxt[gi] = cur[gi-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/crc15_state.sv
// Module: crc15_state
// Purpose: the CRC register with clear, shift and hold selection.
// Assumes: synchronous active-low reset; clear wins over shift.
module crc15_state
    import can_crc15_pkg::*;
#(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_e         upd,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    // Register update according to the selected action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (upd)
                UPD_CLEAR: q <= '0;
                UPD_SHIFT: q <= nxt;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/crc15_judge.sv
// Module: crc15_judge
// Purpose: samples the zero test of the register into a sticky error flag.
// Assumes: the sample strobe arrives at the check delimiter, after the
//          received check bits have been shifted in.
module crc15_judge #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic [W-1:0] crc,
    output logic         err
);
    logic nonzero;

    // Zero detect over the full register
    assign nonzero = |crc;

    // Error flag: loaded on sample, cleared on frame start or reset
    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (clr)    err <= 1'b0;
        else if (sample) err <= nonzero;
    end
endmodule

// File: rtl/can_crc15.sv
// Module: can_crc15 (top)
// Purpose: bit-serial CRC-15 over a destuffed frame stream.
//   - Sending: raise freeze after the data field and read crc_value MSB first.
//   - Receiving: keep feeding through the check field, then pulse crc_sample.
// Assumes: no stuff bits at bit_in; at most one bit per cycle.
module can_crc15
    import can_crc15_pkg::*;
#(
    parameter int               W    = CRC_W_DEF,
    parameter logic [W-1:0]     POLY = POLY_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_clr,
    input  logic         bit_valid,
    input  logic         bit_in,
    input  logic         freeze,
    input  logic         crc_sample,
    output logic [W-1:0] crc_value,
    output logic         crc_error
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nxt;
    upd_e         upd;

    // Action select: clear beats shift; freeze or idle means hold
    always_comb begin
        if (frame_clr)                  upd = UPD_CLEAR;
        else if (bit_valid && !freeze)  upd = UPD_SHIFT;
        else                            upd = UPD_HOLD;
    end

    crc15_next #(.W(W), .POLY(POLY)) u_next (
        .cur (crc_q),
        .din (bit_in),
        .nxt (crc_nxt)
    );

    crc15_state #(.W(W)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .nxt   (crc_nxt),
        .q     (crc_q)
    );

    crc15_judge #(.W(W)) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (frame_clr),
        .sample (crc_sample),
        .crc    (crc_q),
        .err    (crc_error)
    );

    // Output the register directly for MSB-first transmission
    assign crc_value = crc_q;
endmodule

// File: rtl/can_crc15_chk.sv
// Module: can_crc15_chk
// Purpose: temporal checks on the top-level ports, bound into can_crc15.
// Assumes: reset is asserted for at least one edge at start-up.
module can_crc15_chk #(
    parameter int           W    = 15,
    parameter logic [W-1:0] POLY = 15'h4599
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_clr,
    input logic         bit_valid,
    input logic         bit_in,
    input logic         freeze,
    input logic         crc_sample,
    input logic [W-1:0] crc_value,
    input logic         crc_error
);
    // R1: first cycle out of reset shows cleared state
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (crc_value == '0 && !crc_error));

    // R2: frame clear empties register and flag
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (crc_value == '0 && !crc_error));

    // R3: accepted bit with no feedback is a plain shift
    a_r3_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && bit_valid && !freeze && (bit_in == crc_value[W-1]))
        |=> crc_value == {$past(crc_value[W-2:0]), 1'b0});

    // R3: accepted bit with feedback applies the generator
    a_r3_fb_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && bit_valid && !freeze && (bit_in != crc_value[W-1]))
        |=> crc_value == ({$past(crc_value[W-2:0]), 1'b0} ^ POLY));

    // R4: no valid bit, no change
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && !bit_valid) |=> $stable(crc_value));

    // R5: freeze holds the register
    a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && freeze) |=> $stable(crc_value));

    // R7: sample loads non-zero test of the register
    a_r7_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && crc_sample) |=> (crc_error == ($past(crc_value) != '0)));

    // R9: flag is sticky between strobes
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_clr && !crc_sample) |=> $stable(crc_error));
endmodule

bind can_crc15 can_crc15_chk #(.W(W), .POLY(POLY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clr  (frame_clr),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .freeze     (freeze),
    .crc_sample (crc_sample),
    .crc_value  (crc_value),
    .crc_error  (crc_error)
);

// File: tb/sim_can_crc15.sv
// Directed bench for can_crc15: one task per scenario, each self-checking.
module sim_can_crc15;
    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_clr = 1'b0;
    logic         bit_valid = 1'b0;
    logic         bit_in = 1'b0;
    logic         freeze = 1'b0;
    logic         crc_sample = 1'b0;
    logic [W-1:0] crc_value;
    logic         crc_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    can_crc15 u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clr  (frame_clr),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .freeze     (freeze),
        .crc_sample (crc_sample),
        .crc_value  (crc_value),
        .crc_error  (crc_error)
    );

    // 100 MHz clock
    always #5 clk = ~clk;

    // Software model of the shift rule (R3)
    function automatic logic [14:0] ref_step(logic [14:0] c, logic b);
        logic fb;
        fb = b ^ c[14];
        return {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0000);
    endfunction

    function automatic logic [14:0] ref_crc(logic [127:0] w, int len);
        logic [14:0] c;
        c = '0;
        for (int i = 0; i < len; i++) c = ref_step(c, w[i]);
        return c;
    endfunction

    // Append remainder MSB first after len frame bits (R6)
    function automatic logic [127:0] make_code(logic [127:0] w, int len);
        logic [14:0]  c;
        logic [127:0] r;
        c = ref_crc(w, len);
        r = w;
        for (int k = 0; k < 15; k++) r[len+k] = c[14-k];
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; returns at the next one
    task automatic cyc(logic v, logic b, logic f, logic c, logic s);
        bit_valid  = v;
        bit_in     = b;
        freeze     = f;
        frame_clr  = c;
        crc_sample = s;
        @(negedge clk);
    endtask

    task automatic feed(logic [127:0] w, int len);
        cyc(0, 0, 0, 1, 0);
        for (int i = 0; i < len; i++) cyc(1, w[i], 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) cyc(1, 1'b1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        check("R1 crc_value", 32'(crc_value), 32'h0);
        check("R1 crc_error", 32'(crc_error), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_random_frames();
        for (int f = 0; f < 20; f++) begin
            int           len;
            logic [127:0] w;
            len = 19 + int'($urandom % 65);
            w   = {$urandom, $urandom, $urandom, $urandom};
            feed(w, len);
            check("R3 remainder", 32'(crc_value), 32'(ref_crc(w, len)));
        end
    endtask

    task automatic t_codeword_zero();
        for (int f = 0; f < 6; f++) begin
            int           len;
            logic [127:0] w;
            len = 19 + int'($urandom % 65);
            w   = make_code({$urandom, $urandom, $urandom, $urandom}, len);
            feed(w, len + 15);
            check("R6 register zero", 32'(crc_value), 32'h0);
            cyc(0, 0, 0, 0, 1);
            check("R8 clean codeword flag", 32'(crc_error), 32'h0);
        end
    endtask

    task automatic t_idle_freeze_clear();
        logic [14:0] held;
        feed(128'h1234_5678_9abc, 30);
        held = crc_value;
        for (int i = 0; i < 4; i++) cyc(0, i[0], 0, 0, 0);
        check("R4 idle hold", 32'(crc_value), 32'(held));
        for (int i = 0; i < 4; i++) cyc(1, i[0], 1, 0, 0);
        check("R5 freeze hold", 32'(crc_value), 32'(held));
        cyc(1, 1, 0, 1, 1);
        check("R2 clear priority value", 32'(crc_value), 32'h0);
        check("R2 clear priority flag", 32'(crc_error), 32'h0);
    endtask

    task automatic t_flag();
        logic [127:0] w;
        w = 128'h5;
        if (ref_crc(w, 19) == 15'h0) w = 128'h7;
        feed(w, 19);
        cyc(0, 0, 0, 0, 1);
        check("R7 nonzero sample", 32'(crc_error), 32'h1);
        for (int i = 0; i < 5; i++) cyc(1, i[0], 0, 0, 0);
        check("R9 flag sticky", 32'(crc_error), 32'h1);
        cyc(0, 0, 0, 1, 0);
        check("R2 clear flag", 32'(crc_error), 32'h0);
        cyc(0, 0, 0, 0, 1);
        check("R7 zero sample", 32'(crc_error), 32'h0);
    endtask

    task automatic run_bad(logic [127:0] w, int len, string tag);
        feed(w, len);
        cyc(0, 0, 0, 0, 1);
        check(tag, 32'(crc_error), 32'h1);
    endtask

    task automatic t_corruptions();
        logic [127:0] cw;
        logic [127:0] one;
        int           n;
        one = 128'd1;
        n   = 34;
        cw  = make_code({96'h0, $urandom} & 128'h7FFFF, 19);
        for (int p = 0; p < n; p++) run_bad(cw ^ (one << p), n, "R8 single flip");
        for (int p = 0; p < n; p++)
            for (int q = p + 1; q < n; q++)
                run_bad(cw ^ (one << p) ^ (one << q), n, "R8 double flip");
        for (int l = 3; l <= 15; l++)
            for (int s = 0; s + l <= n; s++) begin
                logic [127:0] m;
                m = ({96'h0, $urandom} & ((one << l) - 1)) | one | (one << (l - 1));
                run_bad(cw ^ (m << s), n, "R8 burst");
            end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_random_frames();
        t_codeword_zero();
        t_idle_freeze_clear();
        t_flag();
        t_corruptions();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule